// File: doc/BRIEF.md
# Logical-Time Lease Coherence Controller

This block keeps a small set of shared memory lines coherent across several cores. It tracks no sharers and sends no invalidations. Each line holds its data, a write timestamp and a read timestamp. Every core keeps its own program timestamp and sends it with each request. A load gives the core a lease on the line, and that lease runs until the line's read timestamp. The lease lapses by itself once the core's logical time moves past it. A store jumps the writer's logical time past every lease still outstanding on the line, so no copy held elsewhere has to be recalled.

The cores share one request port per core, and a round-robin arbiter serves one request per clock. The winning request reads its line, goes through the timestamp rules and writes back in the same cycle. The grant, the data and the core's new program timestamp come out registered on the following cycle. A core that holds a cached copy whose lease has lapsed sends a renew request carrying the write timestamp of its copy. The controller reports whether that copy is still current, extends the lease, and returns the line data. Timestamps are 16-bit unsigned values and do not wrap. A result that would overflow is refused and sets an error flag.

Top module: `lease_coherence_ctrl`

## Requirements
- R1: After reset, every line has data 0, write timestamp 0 and read timestamp 0, and gnt_valid and err_ovf are 0.
- R2: A load (op code 2'b00, and also the unused code 2'b11) returns the line data and write timestamp in gnt_data and gnt_wts. It returns gnt_pts = max(request timestamp, line write timestamp).
- R3: A load sets the line read timestamp to max(old read timestamp, gnt_pts + LEASE) and reports that value in gnt_rts.
- R4: A store (op code 2'b01) computes t = max(request timestamp, line read timestamp) + 1. It writes the request data, sets the line's write and read timestamps both to t, and returns gnt_pts = gnt_wts = gnt_rts = t with gnt_data equal to the stored data.
- R5: A request that is selected at a clock edge is answered by a one-cycle gnt_valid pulse right after that edge. gnt_core holds the index of the requesting core. At most one request is served per cycle.
- R6: Arbitration is round-robin: the search starts at the core after the last one granted, and core 0 is first after reset. A core granted in one cycle is not eligible in the next.
- R7: A renew (op code 2'b10) updates timestamps exactly like a load. gnt_renewed is 1 only when the request's cached write timestamp equals the line's write timestamp.
- R8: A load-type result would overflow when max(request timestamp, write timestamp) + LEASE exceeds 65535. A store would overflow when max(request timestamp, read timestamp) equals 65535. In either case the request is granted with gnt_err = 1. The line is left unchanged, gnt_pts returns the request timestamp, gnt_wts, gnt_rts and gnt_data show the line as it stands, gnt_renewed is 0, and err_ovf goes to 1 and stays there until reset.
- R9: A request changes only the line it addresses; the other lines keep their data and timestamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_CORES | Per-core request pending; held until that core's grant |
| req_op | input | 2*N_CORES | Per-core op code: 00 load, 01 store, 10 renew, 11 load |
| req_addr | input | AW*N_CORES | Per-core line index |
| req_pts | input | 16*N_CORES | Per-core program timestamp |
| req_cwts | input | 16*N_CORES | Per-core write timestamp of its cached copy (renew) |
| req_wdata | input | DATA_W*N_CORES | Per-core store data |
| gnt_valid | output | 1 | Grant pulse |
| gnt_core | output | IDW | Index of the granted core |
| gnt_data | output | DATA_W | Line data after the operation |
| gnt_pts | output | 16 | New program timestamp for the core |
| gnt_wts | output | 16 | Line write timestamp after the operation |
| gnt_rts | output | 16 | Line read timestamp (lease end) after the operation |
| gnt_renewed | output | 1 | Renewed copy is still current |
| gnt_err | output | 1 | Request refused for timestamp overflow |
| err_ovf | output | 1 | Sticky overflow flag |

## Verification
The bound checker tests properties on every cycle. Each grant must answer a request that was pending on the previous cycle, and the same core is never granted twice in a row. A returned timestamp never falls below the one the core sent, and the lease end is never earlier than the returned timestamp. A store result must put the write timestamp, the read timestamp and the program timestamp on one common value above the sender's time, and the overflow flag must stay sticky. Some behaviours show only through the bench's scenarios against its own model of the line store. These include the exact lease arithmetic, round-robin order when all cores contend, renew matching, overflow leaving the line untouched, and isolation between lines.

// File: rtl/lease_coh_pkg.sv
package lease_coh_pkg;

    localparam int TSW    = 16;
    localparam int DATA_W = 32;

    typedef logic [TSW-1:0]    ts_t;
    typedef logic [DATA_W-1:0] data_t;

    localparam ts_t TS_MAX = '1;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_RENEW = 2'b10,
        OP_SPARE = 2'b11
    } op_e;

    typedef struct packed {
        ts_t   wts;
        ts_t   rts;
        data_t data;
    } line_t;

    typedef struct packed {
        logic  wr;
        logic  ovf;
        logic  renewed;
        ts_t   pts;
        line_t line_new;
    } res_t;

    function automatic ts_t ts_max(input ts_t a, input ts_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lease_rr_arbiter.sv
module lease_rr_arbiter #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          mask_en,
    input  logic [IW-1:0] mask_id,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_id
);

    logic [IW-1:0] last_q;
    logic [N-1:0]  eligible;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_elig
            assign eligible[gi] = req[gi] && !(mask_en && (int'(mask_id) == gi));
        end
    endgenerate

    always_comb begin
        int idx;
        gnt_any = 1'b0;
        gnt_id  = '0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last_q) + k) % N;
            if (!gnt_any && eligible[idx]) begin
                gnt_any = 1'b1;
                gnt_id  = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N - 1);
        end else if (gnt_any) begin
            last_q <= gnt_id;
        end
    end

endmodule

// File: rtl/lease_line_store.sv
module lease_line_store
    import lease_coh_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int AW     = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output line_t         rd_line,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  line_t         wr_line
);

    line_t lines [N_LINES];

    genvar li;
    generate
        for (li = 0; li < N_LINES; li++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    lines[li] <= '0;
                end else if (wr_en && (int'(wr_addr) == li)) begin
                    lines[li] <= wr_line;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_line = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (int'(rd_addr) == i) begin
                rd_line = lines[i];
            end
        end
    end

endmodule

// File: rtl/lease_ts_engine.sv
module lease_ts_engine
    import lease_coh_pkg::*;
#(
    parameter int LEASE = 10
) (
    input  op_e   op,
    input  ts_t   pts,
    input  ts_t   cwts,
    input  data_t wdata,
    input  line_t cur,
    output res_t  res
);

    localparam int EW = TSW + 1;

    ts_t           p_load;
    logic [EW-1:0] lease_end;
    logic          ovf_load;
    ts_t           m_store;
    logic          ovf_store;

    always_comb begin
        p_load    = ts_max(pts, cur.wts);
        lease_end = {1'b0, p_load} + EW'(LEASE);
        ovf_load  = lease_end[TSW];
        m_store   = ts_max(pts, cur.rts);
        ovf_store = (m_store == TS_MAX);
    end

    always_comb begin
        res          = '0;
        res.line_new = cur;
        res.pts      = pts;
        unique case (op)
            OP_STORE: begin
                if (ovf_store) begin
                    res.ovf = 1'b1;
                end else begin
                    res.wr            = 1'b1;
                    res.pts           = m_store + ts_t'(1);
                    res.line_new.wts  = m_store + ts_t'(1);
                    res.line_new.rts  = m_store + ts_t'(1);
                    res.line_new.data = wdata;
                end
            end
            OP_LOAD, OP_RENEW, OP_SPARE: begin
                if (ovf_load) begin
                    res.ovf = 1'b1;
                end else begin
                    res.wr           = 1'b1;
                    res.pts          = p_load;
                    res.line_new.rts = ts_max(cur.rts, lease_end[TSW-1:0]);
                    res.renewed      = (op == OP_RENEW) && (cwts == cur.wts);
                end
            end
            default: res.ovf = 1'b0;
        endcase
    end

endmodule

// File: rtl/lease_coherence_ctrl.sv
module lease_coherence_ctrl
    import lease_coh_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int N_LINES = 8,
    parameter int LEASE   = 10,
    localparam int AW     = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CORES-1:0]        req_valid,
    input  logic [2*N_CORES-1:0]      req_op,
    input  logic [AW*N_CORES-1:0]     req_addr,
    input  logic [TSW*N_CORES-1:0]    req_pts,
    input  logic [TSW*N_CORES-1:0]    req_cwts,
    input  logic [DATA_W*N_CORES-1:0] req_wdata,
    output logic                      gnt_valid,
    output logic [IDW-1:0]            gnt_core,
    output logic [DATA_W-1:0]         gnt_data,
    output logic [TSW-1:0]            gnt_pts,
    output logic [TSW-1:0]            gnt_wts,
    output logic [TSW-1:0]            gnt_rts,
    output logic                      gnt_renewed,
    output logic                      gnt_err,
    output logic                      err_ovf
);

    logic [1:0]    op_arr    [N_CORES];
    logic [AW-1:0] addr_arr  [N_CORES];
    ts_t           pts_arr   [N_CORES];
    ts_t           cwts_arr  [N_CORES];
    data_t         wdata_arr [N_CORES];

    genvar ci;
    generate
        for (ci = 0; ci < N_CORES; ci++) begin : g_unpack
            assign op_arr[ci]    = req_op[2*ci +: 2];
            assign addr_arr[ci]  = req_addr[AW*ci +: AW];
            assign pts_arr[ci]   = req_pts[TSW*ci +: TSW];
            assign cwts_arr[ci]  = req_cwts[TSW*ci +: TSW];
            assign wdata_arr[ci] = req_wdata[DATA_W*ci +: DATA_W];
        end
    endgenerate

    logic           fire;
    logic [IDW-1:0] win;

    lease_rr_arbiter #(.N(N_CORES)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_valid),
        .mask_en (gnt_valid),
        .mask_id (gnt_core),
        .gnt_any (fire),
        .gnt_id  (win)
    );

    op_e           sel_op;
    logic [AW-1:0] sel_addr;
    ts_t           sel_pts;
    ts_t           sel_cwts;
    data_t         sel_wdata;

    always_comb begin
        sel_op    = OP_LOAD;
        sel_addr  = '0;
        sel_pts   = '0;
        sel_cwts  = '0;
        sel_wdata = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (int'(win) == i) begin
                sel_op    = op_e'(op_arr[i]);
                sel_addr  = addr_arr[i];
                sel_pts   = pts_arr[i];
                sel_cwts  = cwts_arr[i];
                sel_wdata = wdata_arr[i];
            end
        end
    end

    line_t cur_line;
    res_t  res;

    lease_line_store #(.N_LINES(N_LINES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (sel_addr),
        .rd_line (cur_line),
        .wr_en   (fire && res.wr),
        .wr_addr (sel_addr),
        .wr_line (res.line_new)
    );

    lease_ts_engine #(.LEASE(LEASE)) u_eng (
        .op    (sel_op),
        .pts   (sel_pts),
        .cwts  (sel_cwts),
        .wdata (sel_wdata),
        .cur   (cur_line),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid   <= 1'b0;
            gnt_core    <= '0;
            gnt_data    <= '0;
            gnt_pts     <= '0;
            gnt_wts     <= '0;
            gnt_rts     <= '0;
            gnt_renewed <= 1'b0;
            gnt_err     <= 1'b0;
            err_ovf     <= 1'b0;
        end else begin
            gnt_valid <= fire;
            if (fire) begin
                gnt_core    <= win;
                gnt_data    <= res.line_new.data;
                gnt_pts     <= res.pts;
                gnt_wts     <= res.line_new.wts;
                gnt_rts     <= res.line_new.rts;
                gnt_renewed <= res.renewed;
                gnt_err     <= res.ovf;
                if (res.ovf) begin
                    err_ovf <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lease_coh_chk.sv
module lease_coh_chk
    import lease_coh_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int N_LINES = 8,
    localparam int AW     = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_CORES-1:0]     req_valid,
    input logic [2*N_CORES-1:0]   req_op,
    input logic [TSW*N_CORES-1:0] req_pts,
    input logic                   gnt_valid,
    input logic [IDW-1:0]         gnt_core,
    input logic [TSW-1:0]         gnt_pts,
    input logic [TSW-1:0]         gnt_wts,
    input logic [TSW-1:0]         gnt_rts,
    input logic                   gnt_err,
    input logic                   err_ovf
);

    logic [N_CORES-1:0]     prev_valid;
    logic [2*N_CORES-1:0]   prev_op;
    logic [TSW*N_CORES-1:0] prev_pts;

    always_ff @(posedge clk) begin
        prev_valid <= req_valid;
        prev_op    <= req_op;
        prev_pts   <= req_pts;
    end

    logic       sel_valid;
    logic [1:0] sel_op;
    ts_t        sel_pts;

    always_comb begin
        sel_valid = prev_valid[int'(gnt_core)];
        sel_op    = prev_op[2*int'(gnt_core) +: 2];
        sel_pts   = prev_pts[TSW*int'(gnt_core) +: TSW];
    end

    // R5: every grant answers a request pending on the cycle before
    a_r5_grant_had_request: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> sel_valid);

    // R6: no core is granted on two consecutive cycles
    a_r6_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && $past(gnt_valid)) |-> (gnt_core != $past(gnt_core)));

    // R2: the returned program timestamp never moves backwards
    a_r2_pts_forward: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_err) |-> (gnt_pts >= sel_pts));

    // R3: the lease end covers the returned program timestamp
    a_r3_lease_covers: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_err) |-> (gnt_rts >= gnt_pts));

    // R4: a store lands on one timestamp strictly above the sender's
    a_r4_store_bump: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_err && sel_op == 2'b01) |->
            (gnt_pts > sel_pts && gnt_wts == gnt_pts && gnt_rts == gnt_pts));

    // R8: a refused request returns the sender's timestamp and raises the flag
    a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_err) |-> (err_ovf && gnt_pts == sel_pts));

    // R8: the overflow flag stays set
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(err_ovf) |-> err_ovf);

endmodule

bind lease_coherence_ctrl lease_coh_chk #(
    .N_CORES (N_CORES),
    .N_LINES (N_LINES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_pts   (req_pts),
    .gnt_valid (gnt_valid),
    .gnt_core  (gnt_core),
    .gnt_pts   (gnt_pts),
    .gnt_wts   (gnt_wts),
    .gnt_rts   (gnt_rts),
    .gnt_err   (gnt_err),
    .err_ovf   (err_ovf)
);

// File: tb/sim_lease_coherence_ctrl.sv
module sim_lease_coherence_ctrl;

    localparam int NC    = 4;
    localparam int NL    = 8;
    localparam int LEASE = 10;
    localparam int AW    = 3;
    localparam int IDW   = 2;
    localparam int TW    = 16;
    localparam int DW    = 32;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NC-1:0]       req_valid = '0;
    logic [2*NC-1:0]     req_op    = '0;
    logic [AW*NC-1:0]    req_addr  = '0;
    logic [TW*NC-1:0]    req_pts   = '0;
    logic [TW*NC-1:0]    req_cwts  = '0;
    logic [DW*NC-1:0]    req_wdata = '0;
    logic                gnt_valid;
    logic [IDW-1:0]      gnt_core;
    logic [DW-1:0]       gnt_data;
    logic [TW-1:0]       gnt_pts, gnt_wts, gnt_rts;
    logic                gnt_renewed, gnt_err, err_ovf;

    always #2 clk = ~clk;

    lease_coherence_ctrl #(.N_CORES(NC), .N_LINES(NL), .LEASE(LEASE)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_pts(req_pts), .req_cwts(req_cwts),
        .req_wdata(req_wdata), .gnt_valid(gnt_valid), .gnt_core(gnt_core),
        .gnt_data(gnt_data), .gnt_pts(gnt_pts), .gnt_wts(gnt_wts),
        .gnt_rts(gnt_rts), .gnt_renewed(gnt_renewed), .gnt_err(gnt_err),
        .err_ovf(err_ovf)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    int m_wts  [NL];
    int m_rts  [NL];
    int m_data [NL];
    bit m_err  = 0;
    int last_g = NC - 1;
    int core_pts [NC];

    int   p_op   [NC];
    int   p_addr [NC];
    int   p_pts  [NC];
    int   p_cwts [NC];
    int   p_wd   [NC];

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles >= 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung (act %0d cycles, exp < 150000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic post(input int c, input int op, input int addr, input int pts,
                        input int cwts, input int wd);
        p_op[c] = op; p_addr[c] = addr; p_pts[c] = pts; p_cwts[c] = cwts; p_wd[c] = wd;
        req_op[2*c +: 2]     = 2'(op);
        req_addr[AW*c +: AW] = AW'(addr);
        req_pts[TW*c +: TW]  = TW'(pts);
        req_cwts[TW*c +: TW] = TW'(cwts);
        req_wdata[DW*c +: DW] = DW'(wd);
        req_valid[c] = 1'b1;
    endtask

    // model of the requirements; checks one grant for core c
    task automatic check_grant(input int c);
        int op, a, p, e_pts, e_wts, e_rts, e_data, pl, m;
        bit e_err, e_ren;
        op = p_op[c]; a = p_addr[c]; p = p_pts[c];
        e_err = 0; e_ren = 0;
        e_pts = p; e_wts = m_wts[a]; e_rts = m_rts[a]; e_data = m_data[a];
        if (op == 1) begin
            m = (p > m_rts[a]) ? p : m_rts[a];
            if (m == 65535) e_err = 1;
            else begin
                e_pts = m + 1; e_wts = m + 1; e_rts = m + 1; e_data = p_wd[c];
                m_wts[a] = e_wts; m_rts[a] = e_rts; m_data[a] = e_data;
            end
        end else begin
            pl = (p > m_wts[a]) ? p : m_wts[a];
            if (pl + LEASE > 65535) e_err = 1;
            else begin
                e_pts = pl;
                e_rts = (m_rts[a] > pl + LEASE) ? m_rts[a] : pl + LEASE;
                m_rts[a] = e_rts;
                e_ren = (op == 2) && (p_cwts[c] == m_wts[a]);
            end
        end
        if (e_err) m_err = 1;
        chk(gnt_core == IDW'(c), "R5/R6 gnt_core", gnt_core, c);
        chk(gnt_pts == TW'(e_pts), (op == 1) ? "R4 gnt_pts" : "R2 gnt_pts", gnt_pts, e_pts);
        chk(gnt_wts == TW'(e_wts), (op == 1) ? "R4 gnt_wts" : "R2 gnt_wts", gnt_wts, e_wts);
        chk(gnt_rts == TW'(e_rts), (op == 1) ? "R4 gnt_rts" : "R3 gnt_rts", gnt_rts, e_rts);
        chk(gnt_data == DW'(e_data), "R2/R4/R9 gnt_data", gnt_data, e_data);
        chk(gnt_renewed == e_ren, "R7 gnt_renewed", gnt_renewed, e_ren);
        chk(gnt_err == e_err, "R8 gnt_err", gnt_err, e_err);
        chk(err_ovf == m_err, "R8 err_ovf", err_ovf, m_err);
        if (!e_err) core_pts[c] = e_pts;
        last_g = c;
    endtask

    // single request, wait for its grant
    task automatic one(input int c, input int op, input int addr, input int pts,
                       input int cwts, input int wd);
        int w;
        @(negedge clk);
        post(c, op, addr, pts, cwts, wd);
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!gnt_valid && w < 20);
        if (!gnt_valid) chk(0, "R5 grant timeout", w, 1);
        else begin
            chk(w == 1, "R5 grant latency", w, 1);
            check_grant(c);
        end
        req_valid[c] = 1'b0;
        @(negedge clk);
        chk(!gnt_valid, "R5 single pulse", gnt_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NL; i++) begin m_wts[i] = 0; m_rts[i] = 0; m_data[i] = 0; end
        for (int i = 0; i < NC; i++) core_pts[i] = 0;
        repeat (3) @(negedge clk);
        chk(!gnt_valid, "R1 gnt_valid at reset", gnt_valid, 0);
        chk(!err_ovf, "R1 err_ovf at reset", err_ovf, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!gnt_valid, "R1 idle after reset", gnt_valid, 0);

        // R1: fresh line reads as zero; R2/R3 basic load
        one(0, 0, 3, 0, 0, 0);
        one(1, 0, 3, 25, 0, 0);
        // R4: store jumps past the lease held by readers
        one(2, 1, 3, 5, 0, 32'hCAFE0001);
        // R9: neighbour line untouched
        one(3, 0, 4, 0, 0, 0);
        // R2: load with time behind the write timestamp is pulled forward
        one(0, 0, 3, 1, 0, 0);
        // spare op code behaves as load
        one(1, 3, 3, 100, 0, 0);
        // R7: renew matching and stale
        one(2, 2, 3, 100, m_wts[3], 0);
        one(3, 2, 3, 100, m_wts[3] + 5, 0);

        // R6: all cores contend
        for (int round = 0; round < 3; round++) begin
            bit pend [NC];
            int got, exp_c, w;
            @(negedge clk);
            for (int c = 0; c < NC; c++) begin
                post(c, (c + round) % 3, c, core_pts[c], m_wts[c], 32'h100 + c + 16 * round);
                pend[c] = 1;
            end
            got = 0; w = 0;
            while (got < NC && w < 40) begin
                @(negedge clk);
                w++;
                if (gnt_valid) begin
                    exp_c = -1;
                    for (int k = 1; k <= NC; k++)
                        if (exp_c < 0 && pend[(last_g + k) % NC]) exp_c = (last_g + k) % NC;
                    chk(int'(gnt_core) == exp_c, "R6 round-robin order", gnt_core, exp_c);
                    check_grant(int'(gnt_core));
                    pend[int'(gnt_core)] = 0;
                    req_valid[int'(gnt_core)] = 1'b0;
                    got++;
                end
            end
            chk(got == NC, "R6 all contenders served", got, NC);
        end

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int c, op, a, cw;
            c  = $urandom % NC;
            op = $urandom % 4;
            a  = $urandom % NL;
            cw = ($urandom % 2) ? m_wts[a] : m_wts[a] + 1;
            one(c, op, a, core_pts[c] + ($urandom % 4), cw, $urandom);
        end

        // R8: overflow cases; line must stay as it is
        one(0, 1, 6, 65535, 0, 32'hDEAD);
        one(1, 0, 6, 65530, 0, 0);
        one(2, 2, 6, 65526, m_wts[6], 0);
        one(3, 0, 6, 0, 0, 0);
        one(0, 0, 7, 65525, 0, 0);
        one(1, 1, 7, 65535, 0, 32'hBEEF);
        one(2, 1, 2, 9, 0, 32'h55);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule